// File: doc/BRIEF.md
# Serial FIFO Threshold Interrupt Logic

This block sits between a host and a serial shift engine. It holds one FIFO for receive and one for transmit, keeps a count of the valid bytes in each, and raises interrupt requests. The shift engine pushes each completed receive byte into the receive FIFO. The host reads those bytes out from the head of that FIFO. The host writes transmit bytes into the transmit FIFO, and the engine pops them as it starts each transfer.

The receive side raises a level flag once the number of buffered bytes is at least a programmed threshold. A threshold of zero turns that flag off. A byte that arrives while the receive FIFO is full is dropped and sets a sticky overrun flag. The stored contents are left unchanged. The transmit side sets a data-request flag when its FIFO drains empty, and an enable bit gates that flag onto the transmit interrupt. Each FIFO has its own flush strobe.

Top module: `sfifo_irq_ctrl`

## Requirements
- R1: After reset both counts are 0, `rx_full_flag` and `ovr_flag` are 0, `tx_req_flag` is 1, and `tx_irq` equals `tx_irq_en`.
- R2: `rx_count` rises by one for each accepted `eng_rx_valid` and falls by one for each `host_rd` while non-empty. A read of an empty FIFO is ignored. `host_rd_data` always shows the oldest byte, in arrival order.
- R3: `rx_full_flag` is 1 exactly when `rx_thresh` is non-zero and `rx_count >= rx_thresh`, so it clears once host reads bring the count below the threshold.
- R4: With `rx_thresh` = 0, `rx_full_flag` stays 0 at every fill level.
- R5: A byte that arrives when `rx_count` = DEPTH (64) with no read in the same cycle is discarded. The count and the stored bytes are unchanged, and `ovr_flag` is 1 from the next cycle. If a read happens in the same cycle, the byte is accepted instead.
- R6: `ovr_flag` stays set until an `ovr_clr` cycle with no new overrun, because a new overrun wins over a clear. `rx_irq` = `rx_full_flag` OR `ovr_flag`.
- R7: `tx_count` tracks accepted host writes and engine pops. A write while the count is 64 and a pop while the count is 0 are ignored. `eng_tx_data` shows the oldest byte and `eng_tx_avail` is 1 when the count is non-zero.
- R8: `tx_req_flag` is set by a pop that leaves the transmit FIFO empty, and this set wins over `tx_req_clr`. It is cleared by an accepted host write or by `tx_req_clr`.
- R9: `tx_irq` = `tx_req_flag` AND `tx_irq_en`.
- R10: `rx_flush` zeroes `rx_count` and `ovr_flag`. `tx_flush` zeroes `tx_count` and sets `tx_req_flag`. A flush takes priority over a push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_flush | input | 1 | Empties the receive FIFO and clears overrun |
| tx_flush | input | 1 | Empties the transmit FIFO and sets the request flag |
| eng_rx_valid | input | 1 | Engine delivers a completed receive byte |
| eng_rx_data | input | DATA_W | Received byte |
| host_rd | input | 1 | Host pops the receive head |
| host_rd_data | output | DATA_W | Receive FIFO head |
| rx_count | output | CW (7) | Valid bytes in the receive FIFO |
| rx_thresh | input | CW (7) | Receive threshold, 0 disables |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_full_flag | output | 1 | Threshold reached |
| ovr_flag | output | 1 | Sticky overrun |
| rx_irq | output | 1 | Receive interrupt request |
| host_wr | input | 1 | Host pushes a transmit byte |
| host_wr_data | input | DATA_W | Transmit byte |
| tx_count | output | CW (7) | Valid bytes in the transmit FIFO |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | DATA_W | Transmit FIFO head |
| eng_tx_avail | output | 1 | Transmit FIFO is not empty |
| tx_req_clr | input | 1 | Clears the data-request flag |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| tx_req_flag | output | 1 | Transmit FIFO drained |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The receive FIFO is filled one byte at a time from empty to full. At each fill level every threshold from 0 to 64 is applied, which separates an off-by-one in the compare and a broken zero-disable from a correct design. Overrun is exercised three ways: a plain push when full, a push together with a read when full, and a push together with `ovr_clr`. Together these pin down discard, acceptance and set-over-clear priority. The transmit side is filled to capacity, then written past capacity, drained while its byte order is checked, and run through same-cycle drain/clear, write/pop and flush cases, so that the edge where the request flag sets is fixed exactly.

// File: rtl/sfq_pkg.sv
// Package sfq_pkg: shared sizing helper for the serial FIFO interrupt block.
// Assumes FIFO depths are powers of two.
package sfq_pkg;
    // Width needed to hold a count from 0 up to and including depth.
    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/sfq_fifo.sv
// Module sfq_fifo: synchronous FIFO with occupancy count, show-ahead head
// output and a flush strobe. A push into a full FIFO is refused unless a pop
// happens in the same cycle; a refused push is reported on push_drop.
// Assumes DEPTH is a power of two so pointers wrap naturally.
module sfq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = sfq_pkg::cnt_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    // Accept/refuse decisions for this cycle.
    always_comb begin
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        do_pop    = pop && !empty;
        do_push   = push && (!full || do_pop);
        push_drop = push && !do_push;
        rdata     = mem[rd_ptr];
    end

    // Storage write; no reset needed because count gates visibility.
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds capacity.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5: a push into a full FIFO without a pop leaves it full.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));

    // R7: a lone pop on an empty FIFO leaves it empty.
    p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (count == '0));
endmodule

// File: rtl/sfq_rx_flags.sv
// Module sfq_rx_flags: receive threshold compare and sticky overrun flag.
// Assumes drop pulses for exactly the cycles in which a byte was discarded.
module sfq_rx_flags #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] thresh,
    input  logic          drop,
    input  logic          ovr_clr,
    output logic          full_flag,
    output logic          ovr_flag,
    output logic          irq
);
    // Threshold compare on the registered count; zero threshold disables.
    always_comb begin
        full_flag = (thresh != '0) && (count >= thresh);
        irq       = full_flag || ovr_flag;
    end

    // Sticky overrun: flush clears, a new drop wins over a host clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ovr_flag <= 1'b0;
        end else if (drop) begin
            ovr_flag <= 1'b1;
        end else if (ovr_clr) begin
            ovr_flag <= 1'b0;
        end
    end

    // R5: a discarded byte raises overrun on the next cycle.
    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !flush) |=> ovr_flag);

    // R6: overrun holds until cleared or flushed.
    p_ovr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr && !flush) |=> ovr_flag);

    // R10: flush drops overrun.
    p_ovr_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ovr_flag);
endmodule

// File: rtl/sfq_tx_flags.sv
// Module sfq_tx_flags: transmit data-request flag and its interrupt gate.
// Assumes drained is asserted only for a pop that leaves the FIFO empty.
module sfq_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic drained,
    input  logic wr_ok,
    input  logic req_clr,
    input  logic irq_en,
    output logic req_flag,
    output logic irq
);
    // Interrupt gate.
    always_comb irq = req_flag && irq_en;

    // Request flag: set on empty events, cleared by a write or the host.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            req_flag <= 1'b1;
        end else if (drained) begin
            req_flag <= 1'b1;
        end else if (wr_ok || req_clr) begin
            req_flag <= 1'b0;
        end
    end

    // R8: draining to empty raises the request.
    p_drain_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drained && !flush) |=> req_flag);

    // R8: an accepted write without a drain clears the request.
    p_wr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !drained && !flush) |=> !req_flag);

    // R10: flush raises the request.
    p_flush_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> req_flag);
endmodule

// File: rtl/sfifo_irq_ctrl.sv
// Module sfifo_irq_ctrl: receive and transmit FIFOs between a host and a
// serial shift engine, with threshold/overrun receive interrupts and an
// empty-driven transmit request. Assumes DEPTH is a power of two.
module sfifo_irq_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int CW    = sfq_pkg::cnt_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_flush,
    input  logic              tx_flush,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rd_data,
    output logic [CW-1:0]     rx_count,
    input  logic [CW-1:0]     rx_thresh,
    input  logic              ovr_clr,
    output logic              rx_full_flag,
    output logic              ovr_flag,
    output logic              rx_irq,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wr_data,
    output logic [CW-1:0]     tx_count,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              tx_req_clr,
    input  logic              tx_irq_en,
    output logic              tx_req_flag,
    output logic              tx_irq
);
    logic rx_full_unused, rx_empty_unused, rx_drop;
    logic tx_full_unused, tx_empty, tx_drop;
    logic tx_wr_ok, tx_drained;

    sfq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_valid), .wdata(eng_rx_data),
        .pop(host_rd), .rdata(host_rd_data),
        .count(rx_count), .full(rx_full_unused), .empty(rx_empty_unused),
        .push_drop(rx_drop)
    );

    sfq_rx_flags #(.CW(CW)) u_rx_flags (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .count(rx_count), .thresh(rx_thresh), .drop(rx_drop),
        .ovr_clr(ovr_clr), .full_flag(rx_full_flag), .ovr_flag(ovr_flag),
        .irq(rx_irq)
    );

    sfq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(host_wr), .wdata(host_wr_data),
        .pop(eng_tx_pop), .rdata(eng_tx_data),
        .count(tx_count), .full(tx_full_unused), .empty(tx_empty),
        .push_drop(tx_drop)
    );

    // Transmit events: accepted write, and a pop leaving the FIFO empty.
    always_comb begin
        eng_tx_avail = !tx_empty;
        tx_wr_ok     = host_wr && !tx_drop;
        tx_drained   = eng_tx_pop && (tx_count == CW'(1)) && !tx_wr_ok;
    end

    sfq_tx_flags u_tx_flags (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .drained(tx_drained), .wr_ok(tx_wr_ok), .req_clr(tx_req_clr),
        .irq_en(tx_irq_en), .req_flag(tx_req_flag), .irq(tx_irq)
    );

    // R1: leaving reset, the transmit request is raised and receive is quiet.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (tx_req_flag && !ovr_flag && rx_count == '0 && tx_count == '0));
endmodule

// File: tb/tb_sfifo_irq_ctrl.sv
module tb_sfifo_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DEPTH = 64;
    localparam int CW = 7;

    logic clk = 0, rst_n = 0;
    logic rx_flush = 0, tx_flush = 0, eng_rx_valid = 0, host_rd = 0, ovr_clr = 0;
    logic host_wr = 0, eng_tx_pop = 0, tx_req_clr = 0, tx_irq_en = 0;
    logic [DW-1:0] eng_rx_data = 0, host_wr_data = 0;
    logic [CW-1:0] rx_thresh = 0;
    logic [DW-1:0] host_rd_data, eng_tx_data;
    logic [CW-1:0] rx_count, tx_count;
    logic rx_full_flag, ovr_flag, rx_irq, eng_tx_avail, tx_req_flag, tx_irq;

    int n_chk = 0, n_err = 0;
    int rxq[$];
    int txq[$];
    bit done = 0;

    sfifo_irq_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: strobes set beforehand are seen at the posedge, cleared after.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        rx_flush = 0; tx_flush = 0; eng_rx_valid = 0; host_rd = 0; ovr_clr = 0;
        host_wr = 0; eng_tx_pop = 0; tx_req_clr = 0;
    endtask

    task automatic rx_push(input int v);
        eng_rx_valid = 1; eng_rx_data = DW'(v); cyc();
    endtask

    task automatic tx_write(input int v);
        host_wr = 1; host_wr_data = DW'(v); cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 rx_count", int'(rx_count), 0);
        check("R1 tx_count", int'(tx_count), 0);
        check("R1 ovr_flag", int'(ovr_flag), 0);
        check("R1 rx_full_flag", int'(rx_full_flag), 0);
        check("R1 tx_req_flag", int'(tx_req_flag), 1);
        check("R1 tx_irq en0", int'(tx_irq), 0);
        tx_irq_en = 1; #1;
        check("R9 tx_irq en1", int'(tx_irq), 1);
        tx_irq_en = 0;
        @(negedge clk);

        // R2/R3/R4: fill and sweep every threshold at every level
        for (int i = 0; i < DEPTH; i++) begin
            rx_push((i * 5 + 3) & 8'hff);
            rxq.push_back((i * 5 + 3) & 8'hff);
            check("R2 rx_count fill", int'(rx_count), i + 1);
            for (int t = 0; t <= DEPTH; t++) begin
                rx_thresh = CW'(t); #1;
                check(t == 0 ? "R4 thresh zero" : "R3 thresh compare",
                      int'(rx_full_flag), (t != 0 && i + 1 >= t) ? 1 : 0);
            end
            @(negedge clk);
        end

        // R5 overrun discard
        rx_thresh = 0;
        rx_push(8'hEE);
        check("R5 count kept", int'(rx_count), DEPTH);
        check("R5 ovr set", int'(ovr_flag), 1);
        check("R5 head kept", int'(host_rd_data), rxq[0]);
        check("R6 rx_irq from ovr", int'(rx_irq), 1);
        // R6 set wins over clear
        eng_rx_valid = 1; eng_rx_data = 8'hEF; ovr_clr = 1; cyc();
        check("R6 set wins over clr", int'(ovr_flag), 1);
        ovr_clr = 1; cyc();
        check("R6 ovr cleared", int'(ovr_flag), 0);
        check("R6 rx_irq off", int'(rx_irq), 0);
        rx_thresh = 7'd64; #1;
        check("R6 rx_irq from full", int'(rx_irq), 1);

        // R5 push with read at full is accepted
        eng_rx_valid = 1; eng_rx_data = 8'h77; host_rd = 1; cyc();
        void'(rxq.pop_front()); rxq.push_back(8'h77);
        check("R5 push+rd count", int'(rx_count), DEPTH);
        check("R5 push+rd no ovr", int'(ovr_flag), 0);

        // R2/R3 drain with threshold 32
        rx_thresh = 7'd32;
        while (rxq.size() > 0) begin
            check("R2 head order", int'(host_rd_data), rxq[0]);
            host_rd = 1; cyc();
            void'(rxq.pop_front());
            check("R2 rx_count drain", int'(rx_count), rxq.size());
            check("R3 flag on drain", int'(rx_full_flag), rxq.size() >= 32 ? 1 : 0);
        end
        host_rd = 1; cyc();
        check("R2 read empty ignored", int'(rx_count), 0);

        // R10 rx flush with overrun and a concurrent push
        for (int i = 0; i <= DEPTH; i++) rx_push(i);
        check("R5 ovr before flush", int'(ovr_flag), 1);
        rx_flush = 1; eng_rx_valid = 1; eng_rx_data = 8'h11; cyc();
        check("R10 rx flush count", int'(rx_count), 0);
        check("R10 rx flush ovr", int'(ovr_flag), 0);

        // R8/R9 transmit request
        tx_irq_en = 1;
        tx_req_clr = 1; cyc();
        check("R8 req_clr", int'(tx_req_flag), 0);
        check("R9 irq follows req", int'(tx_irq), 0);
        tx_flush = 1; cyc();
        check("R10 tx flush sets req", int'(tx_req_flag), 1);
        for (int i = 0; i < DEPTH; i++) begin
            tx_write((i * 7 + 1) & 8'hff);
            txq.push_back((i * 7 + 1) & 8'hff);
            check("R7 tx_count fill", int'(tx_count), i + 1);
            check("R8 write clears req", int'(tx_req_flag), 0);
        end
        tx_write(8'hAB);
        check("R7 write full ignored", int'(tx_count), DEPTH);
        while (txq.size() > 0) begin
            check("R7 tx head order", int'(eng_tx_data), txq[0]);
            check("R7 avail", int'(eng_tx_avail), 1);
            check("R8 req low while data", int'(tx_req_flag), 0);
            eng_tx_pop = 1; cyc();
            void'(txq.pop_front());
            check("R7 tx_count drain", int'(tx_count), txq.size());
        end
        check("R8 drain sets req", int'(tx_req_flag), 1);
        check("R9 irq on drain", int'(tx_irq), 1);
        check("R7 avail empty", int'(eng_tx_avail), 0);
        tx_irq_en = 0; #1;
        check("R9 irq gated", int'(tx_irq), 0);
        @(negedge clk);
        eng_tx_pop = 1; cyc();
        check("R7 pop empty ignored", int'(tx_count), 0);

        // R8 drain wins over clear; write+pop at one keeps request low
        tx_write(8'h21);
        eng_tx_pop = 1; tx_req_clr = 1; cyc();
        check("R8 drain wins over clr", int'(tx_req_flag), 1);
        tx_write(8'h22);
        eng_tx_pop = 1; host_wr = 1; host_wr_data = 8'h23; cyc();
        check("R7 write+pop count", int'(tx_count), 1);
        check("R8 write+pop no req", int'(tx_req_flag), 0);
        check("R7 write+pop head", int'(eng_tx_data), 8'h23);
        tx_write(8'h24);
        tx_flush = 1; host_wr = 1; cyc();
        check("R10 tx flush count", int'(tx_count), 0);
        check("R10 tx flush req", int'(tx_req_flag), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule